// File: doc/BRIEF.md
# LIN Header Serial Transmitter

This block is the transmit half of a UART-style serial port with an added mode for sending the header of a LIN frame. A host writes bytes into a one-byte holding register and watches an empty flag. The shifter moves each byte onto the line as a start bit, eight data bits least significant bit first, and a stop bit. Every bit boundary is taken from a one-cycle baud tick input.

A host sends a header in three steps. It first raises and lowers a break control bit. It then writes the sync byte 0x55. When the empty flag shows that byte has been taken, it writes the identifier. In master mode the break request holds the line low for a fixed number of bit periods, followed by a high delimiter bit. In slave mode a break request is discarded. The word length is fixed at eight bits.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset `txd` is high, `tx_empty` is 1 and `tx_done` is 0.
- R2: A break request sent in master mode (`slave_mode`=0) drives `txd` low for exactly 13 bit periods.
- R3: A break request made while `slave_mode`=1 is discarded. No low period ever appears on `txd` because of it, and it is not kept for later when the mode changes back to master.
- R4: After the 13 low bits, `txd` stays high for at least one bit period before the next start bit.
- R5: Each byte is sent as one low start bit, then eight data bits with bit 0 first, then one high stop bit, each one bit period long.
- R6: `tx_empty` falls in the cycle after a write (`wr_en`=1). It rises in the cycle after the byte moves from the holding register into the shifter. That move happens on a baud tick at the end of a stop bit, at the end of a delimiter, or while the line is idle.
- R7: `tx_done` rises after the stop bit of a byte when no byte and no break is waiting. A write clears it.
- R8: A break request that arrives while a byte is shifting starts only after that byte's stop bit. A pending break is sent before a byte that is waiting in the holding register.
- R9: A request is the rising edge of `brk_ctrl`. Holding the bit high, or setting and clearing it within one cycle, yields a single break.
- R10: A header written as break, then 0x55, then the identifier (the identifier written once `tx_empty` is 1) goes out back to back, with no idle bit between the sync byte and the identifier.
- R11: `txd` changes only in the cycle after a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse, once per bit period |
| slave_mode | input | 1 | 1 = slave (break requests ignored), 0 = master |
| brk_ctrl | input | 1 | Break control bit; its rising edge is one request |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmission complete |

## Verification
Flags respond to a write one cycle later. The line and `tx_empty` respond to a baud tick one cycle later, since every bit boundary is a register update on the tick. A break request starts its low period at the first tick after the request is registered, or at the end of the current stop bit if a byte is shifting. The bench holds a behavioural model built from a queue of pending line levels. The model advances at each rising edge with the same inputs the design sees, and the design's outputs are compared with it at every falling edge, so each result is checked in exactly the cycle it is due. Low-run lengths on the line are also counted in clock cycles, which checks the break length and the break count directly.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_BRK   = 3'd4,
    ST_DELIM = 3'd5
  } tx_state_e;
endpackage

// File: rtl/lin_brk_ctl.sv
module lin_brk_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_ctrl_i,
  input  logic slave_i,
  input  logic take_i,
  output logic pend_o
);
  logic prev_q, pend_q;
  logic pend_d, req_rise;

  assign req_rise = brk_ctrl_i & ~prev_q;

  always_comb begin
    pend_d = pend_q;
    if (req_rise && !slave_i) pend_d = 1'b1;
    else if (take_i)          pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= brk_ctrl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R3: a request seen in slave mode leaves nothing pending
  assert_slave_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_i && req_rise && !pend_q) |=> !pend_q);
endmodule

// File: rtl/lin_tx_hold.sv
module lin_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (wr_en_i) begin
      full_d = 1'b1;
      data_d = wr_data_i;
    end else if (load_i) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R6: a move into the shifter empties the holding register unless refilled
  assert_empty_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !wr_en_i) |=> !full_o);
endmodule

// File: rtl/lin_tx_shift.sv
module lin_tx_shift
  import lin_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              pend_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_o,
  output logic              take_o,
  output logic              finish_o,
  output logic              txd_o
);
  localparam int MAXB  = (BRK_BITS > DATA_W) ? BRK_BITS : DATA_W;
  localparam int CNT_W = $clog2(MAXB);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] BRK_LAST  = CNT_W'(BRK_BITS - 1);

  tx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              at_bound;

  assign at_bound = tick_i && (st_q == ST_IDLE || st_q == ST_STOP || st_q == ST_DELIM);
  assign take_o   = at_bound && pend_i;
  assign load_o   = at_bound && !pend_i && full_i;
  assign finish_o = at_bound && !pend_i && !full_i && (st_q == ST_STOP);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (tick_i) begin
      unique case (st_q)
        ST_IDLE, ST_STOP, ST_DELIM: begin
          if (pend_i) begin
            st_d  = ST_BRK;
            cnt_d = '0;
          end else if (full_i) begin
            st_d = ST_START;
            sh_d = data_i;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_START: begin
          st_d  = ST_DATA;
          cnt_d = '0;
        end
        ST_DATA: begin
          sh_d = sh_q >> 1;
          if (cnt_q == DATA_LAST) st_d = ST_STOP;
          else                    cnt_d = cnt_q + 1'b1;
        end
        ST_BRK: begin
          if (cnt_q == BRK_LAST) st_d = ST_DELIM;
          else                   cnt_d = cnt_q + 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START, ST_BRK: txd_o = 1'b0;
      ST_DATA:          txd_o = sh_q[0];
      default:          txd_o = 1'b1;
    endcase
  end

  // R11: the line only moves on a bit boundary
  assert_line_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(txd_o));
  // R2: a taken break pulls the line low at once
  assert_break_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !txd_o);
  // R5: a loaded byte begins with a low start bit
  assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !txd_o);
  // R4: the delimiter bit is high
  assert_delim_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DELIM) |-> txd_o);
endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx #(
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              slave_mode,
  input  logic              brk_ctrl,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_done
);
  logic              pend, take, load, finish, full, done_q, done_d;
  logic [DATA_W-1:0] hold_data;

  lin_brk_ctl u_brk (
    .clk(clk), .rst_n(rst_n), .brk_ctrl_i(brk_ctrl), .slave_i(slave_mode),
    .take_i(take), .pend_o(pend)
  );

  lin_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .load_i(load), .data_o(hold_data), .full_o(full)
  );

  lin_tx_shift #(.DATA_W(DATA_W), .BRK_BITS(BRK_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick_i(baud_tick), .pend_i(pend), .full_i(full),
    .data_i(hold_data), .load_o(load), .take_o(take), .finish_o(finish),
    .txd_o(txd)
  );

  always_comb begin
    done_d = done_q;
    if (wr_en)       done_d = 1'b0;
    else if (finish) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign tx_done  = done_q;
  assign tx_empty = ~full;

  // R7: completion implies nothing waits in the holding register
  assert_done_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_empty);
  // R6: a write always fills the holding register
  assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_empty);
endmodule

// File: tb/lin_hdr_tx_tb.sv
module lin_hdr_tx_tb;
  localparam int DIV  = 4;
  localparam int BRKN = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic baud_tick = 1'b0, slave_mode = 1'b0, brk_ctrl = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, tx_empty, tx_done;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  lin_hdr_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .slave_mode(slave_mode),
    .brk_ctrl(brk_ctrl), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
  );

  // reference model: queue of line levels still to come
  bit mq[$];
  bit m_cur = 1, m_act = 0, m_isdata = 0, m_full = 0, m_pend = 0, m_prev = 0, m_done = 0;
  bit [7:0] m_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_cur = 1; m_act = 0; m_isdata = 0; m_full = 0;
      m_pend = 0; m_prev = 0; m_done = 0; m_data = 0;
    end else begin
      bit rise, took, loaded, fin;
      rise = brk_ctrl && !m_prev; took = 0; loaded = 0; fin = 0;
      if (baud_tick) begin
        if (!m_act || mq.size() == 0) begin
          if (m_pend) begin
            took = 1; m_cur = 0; m_act = 1; m_isdata = 0;
            for (int i = 0; i < BRKN - 1; i++) mq.push_back(0);
            mq.push_back(1);
          end else if (m_full) begin
            loaded = 1; m_cur = 0; m_act = 1; m_isdata = 1;
            for (int i = 0; i < 8; i++) mq.push_back(m_data[i]);
            mq.push_back(1);
          end else begin
            if (m_act && m_isdata) fin = 1;
            m_act = 0; m_cur = 1;
          end
        end else m_cur = mq.pop_front();
      end
      if (rise && !slave_mode) m_pend = 1; else if (took) m_pend = 0;
      m_prev = brk_ctrl;
      if (wr_en) begin m_full = 1; m_data = wr_data; m_done = 0; end
      else begin
        if (loaded) m_full = 0;
        if (fin) m_done = 1;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", phase, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  int low_run = 0, max_run = 0, brk_seen = 0;
  bit last_txd = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk("txd", txd, m_cur);
      chk("tx_empty", tx_empty, !m_full);
      chk("tx_done", tx_done, m_done);
      if (!txd) low_run++;
      else if (!last_txd) begin
        if (low_run > max_run) max_run = low_run;
        if (low_run == BRKN * DIV) brk_seen++;
        low_run = 0;
      end
      last_txd = txd;
    end
  end

  // baud tick source
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      baud_tick = (c == DIV - 1);
      c = (c + 1) % DIV;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic pulse_brk();
    @(negedge clk); brk_ctrl = 1;
    @(negedge clk); brk_ctrl = 0;
  endtask
  task automatic wait_empty();
    while (!tx_empty) @(negedge clk);
  endtask
  task automatic wait_done();
    while (!tx_done) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    phase = "watchdog";
    chk("timeout", 1, 0);
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values
    phase = "R1";
    chk("reset txd", txd, 1);
    chk("reset tx_empty", tx_empty, 1);
    chk("reset tx_done", tx_done, 0);

    // R2 R4 R10: master header, sync byte written while break is pending
    phase = "R2_R4_R10";
    step(5);
    pulse_brk();
    put(8'h55);
    wait_empty();
    put(8'h3A);
    wait_done();
    step(8);
    chk("R2 break count", brk_seen, 1);
    chk("R2 longest low run", max_run, BRKN * DIV);

    // R3: slave mode discards request, not kept after switch back
    phase = "R3";
    slave_mode = 1;
    pulse_brk();
    step(80);
    slave_mode = 0;
    step(80);
    chk("R3 no new break", brk_seen, 1);
    chk("R3 line idle", txd, 1);

    // R5 R6 R7: plain bytes with distinct patterns
    phase = "R5_R6_R7";
    put(8'h00);
    wait_empty();
    put(8'hFF);
    wait_empty();
    put(8'h81);
    wait_done();
    step(6);
    chk("R7 done high", tx_done, 1);
    put(8'hC3);
    chk("R7 write clears done", tx_done, 0);
    wait_done();

    // R8: break requested mid-byte, byte waiting behind it
    phase = "R8";
    put(8'hA5);
    wait_empty();
    step(10);
    pulse_brk();
    put(8'h12);
    wait_done();
    step(6);
    chk("R8 break after byte", brk_seen, 2);

    // R9: bit held high gives one break
    phase = "R9";
    @(negedge clk); brk_ctrl = 1;
    step(200);
    brk_ctrl = 0;
    step(40);
    chk("R9 single break", brk_seen, 3);

    // R11: ticks continue, idle line stays put
    phase = "R11";
    step(20);
    chk("R11 idle high", txd, 1);
    finish_run();
  end
endmodule